// File: doc/BRIEF.md
# Slow-Clock System Timer

This block runs on a 32.768 kHz slow clock and holds three independent timers. The first is an interval timer that delivers a periodic tick for an operating system. The second is a watchdog that either requests a system reset or flags an overflow if software fails to restart it in time. The third is a free-running seconds counter with an alarm compare. A small synchronous register port sets the period, reload and alarm values, restarts the watchdog, selects the interrupt enables and reads the counters and the status flags.

Two prescalers feed the timers. One divides the slow clock by `WDOG_DIV`, which is 128 by default. The watchdog counts on that divided clock, so a 16-bit reload reaches 65536 × 128 slow cycles, which is 256 s. The other divides by `SEC_DIV`, which is 32768 by default, and advances the seconds counter. A 20-bit counter therefore spans 1048576 s before it wraps. The four event flags are sticky, a read of the status register clears them, and each flag is gated by its own enable bit into a single interrupt line.

Top module: `slow_sys_timer`

## Requirements
- R1: After reset the status flags, the enables, the reset-mode bit and the seconds counter read zero. The period, reload and alarm registers read all ones. `irq` and `wdResetReq` are low.
- R2: The interval counter is loaded with period P. It decrements once per slow-clock cycle, and in the cycle after it reaches zero it reloads P and sets status bit 0. Flags are therefore P+1 cycles apart. A newly written period takes effect only at the next reload.
- R3: The watchdog counter decrements once every `WDOG_DIV` cycles. A write to address 3 (restart, any data) reloads it with reload value R and restarts the prescaler. Expiry falls (R+1)·`WDOG_DIV` cycles after the restart edge, and the counter then reloads R.
- R4: When mode bit 0 (address 2) is 1, an expiry drives `wdResetReq` high for exactly one cycle and leaves status bit 1 clear.
- R5: When mode bit 0 is 0, an expiry sets status bit 1 and `wdResetReq` stays low.
- R6: A restart issued before expiry postpones the expiry to (R+1)·`WDOG_DIV` cycles after that restart. A restart in the same cycle as a prescaler tick takes priority.
- R7: The seconds counter (address 7) increments once every `SEC_DIV` cycles, sets status bit 3 on each increment, and wraps to zero after 2^`RTC_W` − 1.
- R8: Status bit 2 is set in the cycle where the seconds counter becomes equal to the alarm register (address 4).
- R9: A read of address 6 with `rdEn` high returns the flags {bit3 seconds, bit2 alarm, bit1 watchdog overflow, bit0 period} and clears them at that clock edge. An event in that same cycle leaves its flag set.
- R10: `irq` is high while any status flag is set whose enable bit at address 5 (same bit positions) is 1. Flags still set when their enable bit is 0.
- R11: The map is: 0 period, 1 watchdog reload, 2 mode, 3 restart, 4 alarm, 5 enables, 6 status, 7 seconds. Written values read back zero-extended, and address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | DATA_W | Write data |
| rdEn | input | 1 | Read strobe (clears status at address 6) |
| rdAddr | input | 3 | Read address |
| rdData | output | DATA_W | Read data, combinational from `rdAddr` |
| irq | output | 1 | Combined enabled interrupt |
| wdResetReq | output | 1 | One-cycle watchdog reset request |

## Verification
The assertions assume that `WDOG_DIV` and `SEC_DIV` are at least 2, so that prescaler ticks and reset pulses can never fall on back-to-back cycles. They also assume that all port inputs are synchronous to the slow clock. The bench drives every input on the falling edge and issues one register access per cycle. It uses small divisors and 4-bit counters, so that every expiry, alarm and wrap falls on a cycle it computes from the reset edge.

// File: rtl/slow_timer_pkg.sv
package slow_timer_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_PERIOD  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_RELOAD  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_MODE    = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_RESTART = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_ALARM   = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_ENABLE  = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_STATUS  = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_SECONDS = 3'd7;

  localparam int FLAG_N = 4;
  localparam int FL_PERIOD = 0;
  localparam int FL_WDOG   = 1;
  localparam int FL_ALARM  = 2;
  localparam int FL_SEC    = 3;

  typedef struct packed {
    logic wrPeriod;
    logic wrReload;
    logic wrMode;
    logic restart;
    logic wrAlarm;
    logic wrEnable;
    logic statusRead;
    logic wdTick;
    logic secTick;
  } tmrStrobe_t;
endpackage

// File: rtl/slow_timer_ctrl.sv
module slow_timer_ctrl
  import slow_timer_pkg::*;
#(
  parameter int WDOG_DIV = 128,
  parameter int SEC_DIV  = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output tmrStrobe_t        strobe
);
  localparam int WPW = $clog2(WDOG_DIV);
  localparam int SPW = $clog2(SEC_DIV);
  localparam logic [WPW-1:0] WP_LAST = WPW'(WDOG_DIV - 1);
  localparam logic [SPW-1:0] SP_LAST = SPW'(SEC_DIV - 1);

  logic [WPW-1:0] wdPre;
  logic [SPW-1:0] secPre;

  always_comb begin
    strobe.wrPeriod   = wrEn && (wrAddr == ADR_PERIOD);
    strobe.wrReload   = wrEn && (wrAddr == ADR_RELOAD);
    strobe.wrMode     = wrEn && (wrAddr == ADR_MODE);
    strobe.restart    = wrEn && (wrAddr == ADR_RESTART);
    strobe.wrAlarm    = wrEn && (wrAddr == ADR_ALARM);
    strobe.wrEnable   = wrEn && (wrAddr == ADR_ENABLE);
    strobe.statusRead = rdEn && (rdAddr == ADR_STATUS);
    strobe.wdTick     = (wdPre == WP_LAST);
    strobe.secTick    = (secPre == SP_LAST);
  end

  // watchdog prescaler restarts together with the watchdog counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdPre <= '0;
    end else if (strobe.restart || strobe.wdTick) begin
      wdPre <= '0;
    end else begin
      wdPre <= wdPre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secPre <= '0;
    end else if (strobe.secTick) begin
      secPre <= '0;
    end else begin
      secPre <= secPre + 1'b1;
    end
  end

  // R3: watchdog ticks are never on consecutive cycles
  a_r3_wd_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wdTick |=> !strobe.wdTick);
  // R6: a restart leaves at least one tick-free cycle behind it
  a_r6_restart_clears_pre: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> !strobe.wdTick);
  // R7: seconds ticks are never on consecutive cycles
  a_r7_sec_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    strobe.secTick |=> !strobe.secTick);
endmodule

// File: rtl/slow_timer_datapath.sv
module slow_timer_datapath
  import slow_timer_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int WDOG_W   = 16,
  parameter int RTC_W    = 20,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              wdResetReq
);
  logic [PERIOD_W-1:0] periodReg, pitCnt;
  logic [WDOG_W-1:0]   reloadReg, wdCnt;
  logic [RTC_W-1:0]    alarmReg, secCnt, secNext;
  logic                modeRst;
  logic [FLAG_N-1:0]   enReg, statusReg, evt;
  logic                pitEvt, wdExpire, alarmEvt;
  logic                unusedData;

  assign unusedData = ^wrData;
  assign pitEvt   = (pitCnt == '0);
  assign wdExpire = strobe.wdTick && !strobe.restart && (wdCnt == '0);
  assign secNext  = secCnt + 1'b1;
  assign alarmEvt = strobe.secTick && (secNext == alarmReg);

  always_comb begin
    evt = '0;
    evt[FL_PERIOD] = pitEvt;
    evt[FL_WDOG]   = wdExpire && !modeRst;
    evt[FL_ALARM]  = alarmEvt;
    evt[FL_SEC]    = strobe.secTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg <= '1;
      reloadReg <= '1;
      alarmReg  <= '1;
      modeRst   <= 1'b0;
      enReg     <= '0;
    end else begin
      if (strobe.wrPeriod) periodReg <= wrData[PERIOD_W-1:0];
      if (strobe.wrReload) reloadReg <= wrData[WDOG_W-1:0];
      if (strobe.wrAlarm)  alarmReg  <= wrData[RTC_W-1:0];
      if (strobe.wrMode)   modeRst   <= wrData[0];
      if (strobe.wrEnable) enReg     <= wrData[FLAG_N-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pitCnt     <= '1;
      wdCnt      <= '1;
      secCnt     <= '0;
      statusReg  <= '0;
      wdResetReq <= 1'b0;
    end else begin
      pitCnt <= pitEvt ? periodReg : pitCnt - 1'b1;
      if (strobe.restart) begin
        wdCnt <= reloadReg;
      end else if (strobe.wdTick) begin
        wdCnt <= (wdCnt == '0) ? reloadReg : wdCnt - 1'b1;
      end
      if (strobe.secTick) secCnt <= secNext;
      statusReg  <= (strobe.statusRead ? '0 : statusReg) | evt;
      wdResetReq <= wdExpire && modeRst;
    end
  end

  assign irq = |(statusReg & enReg);

  always_comb begin
    case (rdAddr)
      ADR_PERIOD:  rdData = DATA_W'(periodReg);
      ADR_RELOAD:  rdData = DATA_W'(reloadReg);
      ADR_MODE:    rdData = DATA_W'(modeRst);
      ADR_ALARM:   rdData = DATA_W'(alarmReg);
      ADR_ENABLE:  rdData = DATA_W'(enReg);
      ADR_STATUS:  rdData = DATA_W'(statusReg);
      ADR_SECONDS: rdData = DATA_W'(secCnt);
      default:     rdData = '0;
    endcase
  end

  // R2: a period flag only appears after the counter sat at zero
  a_r2_period_from_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReg[FL_PERIOD]) |-> ($past(pitCnt) == '0));
  // R3: a restart loads the reload value
  a_r3_restart_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (wdCnt == $past(reloadReg)));
  // R4: the reset request is a single-cycle pulse
  a_r4_rst_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wdResetReq |=> !wdResetReq);
  // R5: overflow flag needs a tick with reset mode off
  a_r5_flag_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReg[FL_WDOG]) |-> ($past(strobe.wdTick) && !$past(modeRst)));
  // R7: seconds counter steps by one on a tick and holds otherwise
  a_r7_sec_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.secTick |=> (secCnt == RTC_W'($past(secCnt) + 1'b1)));
  a_r7_sec_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.secTick |=> $stable(secCnt));
endmodule

// File: rtl/slow_sys_timer.sv
module slow_sys_timer
  import slow_timer_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int WDOG_W   = 16,
  parameter int RTC_W    = 20,
  parameter int WDOG_DIV = 128,
  parameter int SEC_DIV  = 32768,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [2:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              wdResetReq
);
  tmrStrobe_t strobe;

  slow_timer_ctrl #(.WDOG_DIV(WDOG_DIV), .SEC_DIV(SEC_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .rdEn(rdEn), .rdAddr(rdAddr), .strobe(strobe)
  );

  slow_timer_datapath #(
    .PERIOD_W(PERIOD_W), .WDOG_W(WDOG_W), .RTC_W(RTC_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irq(irq), .wdResetReq(wdResetReq)
  );
endmodule

// File: tb/slow_sys_timer_bench.sv
`timescale 1ns/1ps
module slow_sys_timer_bench;
  localparam int PW = 4, WW = 4, RW = 4, WDIV = 4, SDIV = 8, DW = 32;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0] wrAddr = '0, rdAddr = '0;
  logic [DW-1:0] wrData = '0, rdData;
  logic irq, wdResetReq;
  int edgeCnt;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) edgeCnt <= 0;
    else       edgeCnt <= edgeCnt + 1;
  end

  slow_sys_timer #(.PERIOD_W(PW), .WDOG_W(WW), .RTC_W(RW), .WDOG_DIV(WDIV),
                   .SEC_DIV(SDIV), .DATA_W(DW)) u_slow_sys_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .irq(irq), .wdResetReq(wdResetReq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, edgeCnt);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] v);
    rdEn = 1'b1; rdAddr = a;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitEdge(input int n);
    while (edgeCnt < n) @(negedge clk);
  endtask

  // sel 0: irq, sel 1: wdResetReq; returns the edge count of the first high sample
  task automatic poll(input bit sel, output int at);
    at = -1;
    for (int i = 0; i < 300; i++) begin
      if ((sel ? wdResetReq : irq) === 1'b1) begin
        at = edgeCnt;
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    logic [DW-1:0] v;
    int at, prev;

    // R1 reset state, R11 map readback
    doReset();
    chk(irq === 1'b0, "R1 irq", irq, 0);
    chk(wdResetReq === 1'b0, "R1 wdResetReq", wdResetReq, 0);
    rd(3'd6, v); chk(v == 0, "R1 status", v, 0);
    rd(3'd7, v); chk(v == 0, "R1 seconds", v, 0);
    rd(3'd0, v); chk(v == 15, "R1 period", v, 15);
    rd(3'd1, v); chk(v == 15, "R1 reload", v, 15);
    rd(3'd4, v); chk(v == 15, "R1 alarm", v, 15);
    rd(3'd5, v); chk(v == 0, "R1 enables", v, 0);
    rd(3'd2, v); chk(v == 0, "R1 mode", v, 0);
    wr(3'd4, 32'd9);  rd(3'd4, v); chk(v == 9, "R11 alarm readback", v, 9);
    wr(3'd1, 32'hFFF6); rd(3'd1, v); chk(v == 6, "R11 reload readback", v, 6);
    wr(3'd3, 32'd1);  rd(3'd3, v); chk(v == 0, "R11 restart reads zero", v, 0);
    wr(3'd5, 32'd5);  rd(3'd5, v); chk(v == 5, "R11 enable readback", v, 5);

    // R2 interval timer: first reload uses the old period
    doReset();
    wr(3'd5, 32'd1);
    wr(3'd0, 32'd3);
    poll(0, at); chk(at == 16, "R2 first period flag", at, 16);
    rd(3'd6, v); chk(v[0] == 1'b1, "R2 period bit", v[0], 1);
    prev = at;
    poll(0, at); chk(at - prev == 4, "R2 spacing P+1", at - prev, 4);
    rd(3'd6, v);
    prev = at;
    poll(0, at); chk(at - prev == 4, "R2 spacing repeat", at - prev, 4);

    // R9/R10 clear on read, masked flags, set wins over clear
    doReset();
    waitEdge(16);
    chk(irq === 1'b0, "R10 disabled flags keep irq low", irq, 0);
    rd(3'd6, v); chk(v[3:0] == 4'b1001, "R9 flags read", v[3:0], 9);
    rd(3'd6, v); chk(v[3:0] == 4'b0000, "R9 cleared after read", v[3:0], 0);
    waitEdge(23);
    rd(3'd6, v); chk(v[3:0] == 4'b0000, "R9 quiet read", v[3:0], 0);
    rd(3'd6, v); chk(v[3:0] == 4'b1000, "R9 same-cycle event kept", v[3:0], 8);

    // R5 expiry without reset mode, R3 timing
    doReset();
    wr(3'd5, 32'd2);
    wr(3'd1, 32'd2);
    wr(3'd3, 32'd0);
    poll(0, at); chk(at == 15, "R3 R5 expiry edge", at, 15);
    chk(wdResetReq === 1'b0, "R5 no reset request", wdResetReq, 0);
    rd(3'd6, v); chk(v[1] == 1'b1, "R5 overflow flag", v[1], 1);
    chk(wdResetReq === 1'b0, "R5 no reset request later", wdResetReq, 0);

    // R4 reset-request pulse
    doReset();
    wr(3'd2, 32'd1);
    wr(3'd1, 32'd1);
    wr(3'd3, 32'd0);
    poll(1, at); chk(at == 11, "R4 reset request edge", at, 11);
    @(negedge clk);
    chk(wdResetReq === 1'b0, "R4 single cycle", wdResetReq, 0);
    rd(3'd6, v); chk(v[1] == 1'b0, "R4 no overflow flag", v[1], 0);

    // R6 restart in time postpones expiry
    doReset();
    wr(3'd2, 32'd1);
    wr(3'd1, 32'd1);
    wr(3'd3, 32'd0);
    waitEdge(8);
    wr(3'd3, 32'd0);
    poll(1, at); chk(at == 17, "R6 postponed expiry", at, 17);

    // R7 seconds flag
    doReset();
    wr(3'd5, 32'd8);
    poll(0, at); chk(at == 8, "R7 seconds flag edge", at, 8);

    // R8 alarm, R7 count and wrap
    doReset();
    wr(3'd4, 32'd5);
    wr(3'd5, 32'd4);
    poll(0, at); chk(at == 40, "R8 alarm edge", at, 40);
    rd(3'd7, v); chk(v == 5, "R8 count at alarm", v, 5);
    waitEdge(121);
    rd(3'd7, v); chk(v == 15, "R7 top count", v, 15);
    waitEdge(130);
    rd(3'd7, v); chk(v == 0, "R7 wrap", v, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule